// File: doc/BRIEF.md
# Power-Fail Reset Supervisor

This block is the digital half of a supply supervisor. It takes two raw comparator results: the main supply is under the power-fail trip level, and the main supply is under the backup cell voltage. From these it produces three outputs. The first is an active-low system reset that goes to an open-drain pad. The second is an inhibit that stops the bus interface from touching the counter registers. The third selects whether the chip runs from the main supply or from the backup source.

A loss of supply is acted on quickly. The supply inputs are synchronised, and the trip direction of the power-fail input bypasses all filtering, so reset and inhibit follow within a few core clocks. Recovery is deliberately slow. The power-fail input must stay good for a debounce window of timebase ticks. Reset is then held for a fixed number of ticks, and that count starts again from zero if the supply dips during it. When the oscillator-disable control bit is set, reset is also held until the oscillator reports that it is running. The timebase is a single-cycle clock-enable pulse, typically at 1 kHz, so the default of 250 ticks gives 250 ms. The block comes out of reset asserting system reset and then runs the full release sequence, exactly as after a power failure.

Top module: `pfs_supervisor`

## Requirements
- R1: While `rst_n` is low and right after it, `sys_rst_n` = 0, `bus_inhibit` = 1 and `sel_backup` = 0.
- R2: From a cycle in which `vmain_below_pf` goes to 1, `sys_rst_n` is 0 and `bus_inhibit` is 1 within 4 clock cycles, with no `tick` required.
- R3: Once `vmain_below_pf` is 0 and stays 0, `sys_rst_n` stays 0 for at least DELAY_TICKS ticks and goes to 1 within DEB_TICKS + DELAY_TICKS + 2 ticks. This also applies to the first release after reset.
- R4: A return of `vmain_below_pf` to 1 while reset is being stretched drops the progress made so far. After the supply recovers again, the full R3 delay applies, counted from that recovery.
- R5: With `osc_disable` = 1 and `osc_ready` = 0, `sys_rst_n` stays 0 after the delay has expired. It goes to 1 within 4 clock cycles of `osc_ready` rising.
- R6: With `osc_disable` = 0, `osc_ready` has no effect and release follows R3.
- R7: After the inputs have been steady for more than DEB_TICKS ticks, `sel_backup` = 1 only for the input pair `vmain_below_pf` = 1 and `vmain_below_bk` = 1; the other three pairs give 0.
- R8: After the inputs have settled, `bus_inhibit` equals the filtered `vmain_below_pf` whatever the value of `vmain_below_bk`, so access is allowed during the reset stretch.
- R9: A change on `vmain_below_bk` that lasts fewer than DEB_TICKS consecutive ticks leaves `sel_backup` unchanged. A change held for DEB_TICKS ticks takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| tick | input | 1 | Timebase enable, one cycle wide |
| vmain_below_pf | input | 1 | Raw comparator: main supply under the power-fail trip level |
| vmain_below_bk | input | 1 | Raw comparator: main supply under the backup voltage |
| osc_disable | input | 1 | Oscillator-disable control bit |
| osc_ready | input | 1 | Raw oscillator-running indication |
| sys_rst_n | output | 1 | Active-low system reset (0 turns the open-drain pull-down on) |
| bus_inhibit | output | 1 | 1 blocks register access from the bus interface |
| sel_backup | output | 1 | 1 selects the backup source, 0 selects the main supply |

## Verification
A corrupted supervisor state shows up at `sys_rst_n`. If the state machine leaves the tripped state too early, reset releases well before DELAY_TICKS ticks. If it sticks, reset never releases, and the bench sees this within one delay window. A wrong stretch counter, one not restarted on a dip, releases too early after a second recovery. Filter faults show as `sel_backup` following a two-tick glitch, or as a trip that takes longer than 4 clocks to reach reset and inhibit. These are checked in the cycle where each effect is due.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    ST_TRIP    = 2'd0,
    ST_STRETCH = 2'd1,
    ST_OSCWAIT = 2'd2,
    ST_RUN     = 2'd3
  } sup_state_t;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1, stg2;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg1[gi] <= RST_VAL[gi];
          stg2[gi] <= RST_VAL[gi];
        end else begin
          stg1[gi] <= d[gi];
          stg2[gi] <= stg1[gi];
        end
      end
    end
  endgenerate

  assign q = stg2;
endmodule

// File: rtl/pfs_filter.sv
// Tick-based debouncer. FAST_SET=1: a 1 on din sets q at once, and q
// clears only after DEB_TICKS consecutive ticks of 0. FAST_SET=0: q takes
// the new value after DEB_TICKS consecutive ticks that disagree with it.
module pfs_filter #(
  parameter int   DEB_TICKS = 3,
  parameter bit   FAST_SET  = 1'b0,
  parameter logic RST_VAL   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic q
);
  localparam int CW = (DEB_TICKS < 2) ? 1 : $clog2(DEB_TICKS);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic [CW-1:0] cnt;
  logic          q_r;

  generate
    if (FAST_SET) begin : g_fast
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_r <= RST_VAL;
          cnt <= '0;
        end else if (din) begin
          q_r <= 1'b1;
          cnt <= '0;
        end else if (!q_r) begin
          cnt <= '0;
        end else if (tick) begin
          if (cnt == LAST) begin
            q_r <= 1'b0;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end

      assert_fast_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        din |=> q_r);
    end else begin : g_sym
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_r <= RST_VAL;
          cnt <= '0;
        end else if (din == q_r) begin
          cnt <= '0;
        end else if (tick) begin
          if (cnt == LAST) begin
            q_r <= din;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end

      assert_change_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(q_r));
    end
  endgenerate

  assign q = q_r;
endmodule

// File: rtl/pfs_delay.sv
// Stretch counter: counts ticks while enabled and holds at DELAY_TICKS.
module pfs_delay #(
  parameter int DELAY_TICKS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(DELAY_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (tick && !done)    cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);
  assert_clear_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !done);
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor #(
  parameter int DEB_TICKS   = 3,
  parameter int DELAY_TICKS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic vmain_below_pf,
  input  logic vmain_below_bk,
  input  logic osc_disable,
  input  logic osc_ready,
  output logic sys_rst_n,
  output logic bus_inhibit,
  output logic sel_backup
);
  import pfs_pkg::*;

  // Synchronised inputs, bit order {osc, bk, pf}; pf resets to "tripped".
  logic [2:0] raw_v, sync_v;
  assign raw_v = {osc_ready, vmain_below_bk, vmain_below_pf};

  pfs_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_v), .q(sync_v)
  );

  logic pf_low_q, bk_low_q, osc_s;
  assign osc_s = sync_v[2];

  pfs_filter #(.DEB_TICKS(DEB_TICKS), .FAST_SET(1'b1), .RST_VAL(1'b1)) u_pf_flt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .din(sync_v[0]), .q(pf_low_q)
  );

  pfs_filter #(.DEB_TICKS(DEB_TICKS), .FAST_SET(1'b0), .RST_VAL(1'b0)) u_bk_flt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .din(sync_v[1]), .q(bk_low_q)
  );

  sup_state_t state, state_nx;
  logic       dly_done;

  pfs_delay #(.DELAY_TICKS(DELAY_TICKS)) u_delay (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_TRIP), .tick(tick), .done(dly_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_TRIP:    if (!pf_low_q) state_nx = ST_STRETCH;
      ST_STRETCH: begin
        if (pf_low_q)                    state_nx = ST_TRIP;
        else if (dly_done)
          state_nx = (osc_disable && !osc_s) ? ST_OSCWAIT : ST_RUN;
      end
      ST_OSCWAIT: begin
        if (pf_low_q)                    state_nx = ST_TRIP;
        else if (osc_s || !osc_disable)  state_nx = ST_RUN;
      end
      ST_RUN:     if (pf_low_q) state_nx = ST_TRIP;
      default:    state_nx = ST_TRIP;
    endcase
  end

  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_TRIP;
      sel_q <= 1'b0;
    end else begin
      state <= state_nx;
      sel_q <= pf_low_q & bk_low_q;
    end
  end

  assign sys_rst_n   = (state == ST_RUN);
  assign bus_inhibit = pf_low_q;
  assign sel_backup  = sel_q;

  assert_trip_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_low_q && state != ST_TRIP) |=> state == ST_TRIP);
  assert_release_after_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(dly_done));
  assert_osc_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sys_rst_n) && $past(osc_disable)) |-> $past(osc_s));
  assert_backup_in_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_backup |-> !sys_rst_n);
  assert_inhibit_then_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_inhibit |=> !sys_rst_n);
endmodule

// File: tb/sim_pfs_supervisor.sv
module sim_pfs_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int DEB        = 3;
  localparam int DLY        = 250;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic pf = 1'b1, bk = 1'b0, odis = 1'b0, ordy = 1'b0;
  logic sys_rst_n, bus_inhibit, sel_backup;
  int   tests = 0, fails = 0;
  bit   finished = 1'b0;
  int   tdiv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
    tick <= (tdiv == TICK_DIV-1);
  end

  pfs_supervisor #(.DEB_TICKS(DEB), .DELAY_TICKS(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .vmain_below_pf(pf), .vmain_below_bk(bk),
    .osc_disable(odis), .osc_ready(ordy),
    .sys_rst_n(sys_rst_n), .bus_inhibit(bus_inhibit), .sel_backup(sel_backup)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_R1;
    chk("R1", "sys_rst_n in reset", sys_rst_n, 1'b0);
    chk("R1", "bus_inhibit in reset", bus_inhibit, 1'b1);
    rst_n = 1'b1;
    clks(1);
    chk("R1", "sys_rst_n after reset", sys_rst_n, 1'b0);
    chk("R1", "bus_inhibit after reset", bus_inhibit, 1'b1);
    chk("R1", "sel_backup after reset", sel_backup, 1'b0);
  endtask

  task automatic t_powerup_R3;
    pf = 1'b0;
    clks(DLY*TICK_DIV);
    chk("R3", "still held before delay", sys_rst_n, 1'b0);
    chk("R8", "access allowed during stretch", bus_inhibit, 1'b0);
    clks((DEB+2)*TICK_DIV + 4);
    chk("R3", "released after delay", sys_rst_n, 1'b1);
  endtask

  task automatic t_trip_R2;
    pf = 1'b1;
    clks(4);
    chk("R2", "reset within 4 clocks", sys_rst_n, 1'b0);
    chk("R2", "inhibit within 4 clocks", bus_inhibit, 1'b1);
  endtask

  task automatic t_redip_R4;
    pf = 1'b0;
    clks(200*TICK_DIV);
    pf = 1'b1;
    clks(20);
    chk("R4", "reset during dip", sys_rst_n, 1'b0);
    pf = 1'b0;
    clks(DLY*TICK_DIV);
    chk("R4", "delay restarted after dip", sys_rst_n, 1'b0);
    clks((DEB+2)*TICK_DIV + 4);
    chk("R4", "release after full delay", sys_rst_n, 1'b1);
  endtask

  task automatic t_osc_R5;
    pf = 1'b1; odis = 1'b1; ordy = 1'b0;
    clks(20);
    pf = 1'b0;
    clks((DLY+DEB+20)*TICK_DIV);
    chk("R5", "held while oscillator not ready", sys_rst_n, 1'b0);
    ordy = 1'b1;
    clks(4);
    chk("R5", "released after oscillator ready", sys_rst_n, 1'b1);
  endtask

  task automatic t_osc_ignored_R6;
    pf = 1'b1; odis = 1'b0; ordy = 1'b0;
    clks(20);
    pf = 1'b0;
    clks(DLY*TICK_DIV);
    chk("R6", "held before delay", sys_rst_n, 1'b0);
    clks((DEB+2)*TICK_DIV + 4);
    chk("R6", "release ignores osc_ready", sys_rst_n, 1'b1);
  endtask

  task automatic t_table_R7_R8;
    pf = 1'b1; bk = 1'b1; clks(8*TICK_DIV);
    chk("R7", "pf1 bk1 sel", sel_backup, 1'b1);
    chk("R8", "pf1 bk1 inhibit", bus_inhibit, 1'b1);
    pf = 1'b1; bk = 1'b0; clks(8*TICK_DIV);
    chk("R7", "pf1 bk0 sel", sel_backup, 1'b0);
    chk("R8", "pf1 bk0 inhibit", bus_inhibit, 1'b1);
    pf = 1'b0; bk = 1'b1; clks(8*TICK_DIV);
    chk("R7", "pf0 bk1 sel", sel_backup, 1'b0);
    chk("R8", "pf0 bk1 inhibit", bus_inhibit, 1'b0);
    pf = 1'b0; bk = 1'b0; clks(8*TICK_DIV);
    chk("R7", "pf0 bk0 sel", sel_backup, 1'b0);
    chk("R8", "pf0 bk0 inhibit", bus_inhibit, 1'b0);
  endtask

  task automatic t_glitch_R9;
    logic seen;
    pf = 1'b1; bk = 1'b0; clks(8*TICK_DIV);
    seen = 1'b0;
    bk = 1'b1;
    for (int i = 0; i < 2*TICK_DIV; i++) begin clks(1); seen |= sel_backup; end
    bk = 1'b0;
    for (int i = 0; i < 6*TICK_DIV; i++) begin clks(1); seen |= sel_backup; end
    chk("R9", "short bk glitch ignored", seen, 1'b0);
    bk = 1'b1; clks((DEB+2)*TICK_DIV);
    chk("R9", "held bk change accepted", sel_backup, 1'b1);
  endtask

  initial begin
    clks(5);
    t_reset_R1();
    t_powerup_R3();
    t_trip_R2();
    t_redip_R4();
    t_osc_R5();
    t_osc_ignored_R6();
    t_table_R7_R8();
    t_glitch_R9();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule